// File: doc/BRIEF.md
# Serial Output Power and Lock-Wait Controller

This block decides what the output stage of a serial transmitter is doing at any moment. It can be in one of three states. It can be switched off, with the termination removed and the driver in high impedance. It can be idle, with the termination connected and the driver still off, so the two output legs are pulled together and the differential voltage is zero. It can be active, driving serial data. The block follows an active-low power-down request and an input-supply-present flag. The power-down path removes the output at once, with no clock edge needed, but it only releases through a two-stage synchronizer clocked by the pixel clock.

After release, a fixed lock wait is counted in pixel clocks to stand in for the PLL settling time. Only when that count has run out are the driver enable and the lock flag raised, in the same cycle. Any return to power-down, and any change of the two-bit frequency range select, restarts the wait from zero.

The range select is also registered and decoded into a one-hot band code, which the clock generator uses to pick its frequency band.

Top module: `pwr_lock_ctrl`

## Requirements
- R1: While `rst_n` is low, `term_en`, `drv_en` and `locked` are 0 and `band_oh` is 4'b0001.
- R2: When `run_req` is low, `term_en` and `drv_en` are 0 immediately, without waiting for a clock edge.
- R3: When `vin_ok` is low, the block behaves exactly as if `run_req` were low, whatever the level of `run_req`.
- R4: After `run_req` and `vin_ok` are both high, `term_en` rises on the second rising clock edge, and `drv_en` stays 0 at that point (idle state).
- R5: `drv_en` rises exactly LOCK_CYCLES (default 16385) rising edges after the edge on which `term_en` rose, provided the range select stays stable.
- R6: `locked` equals `drv_en` in every cycle.
- R7: Each power-down, however short, discards any partial wait. The next release needs the full LOCK_CYCLES wait again.
- R8: A change of `freq_sel` clears `drv_en` on the next rising edge. `drv_en` then rises again LOCK_CYCLES edges after that edge.
- R9: `band_oh` is one-hot with bit k set for select value k: 0 selects 3–5 MHz, 1 selects 5–10 MHz, 2 selects 10–20 MHz and 3 selects 20–35 MHz. It follows `freq_sel` one rising edge later.
- R10: `drv_en` is never 1 while `term_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| run_req | input | 1 | Asynchronous power-down request, low means power down |
| vin_ok | input | 1 | Input supply present; low forces power-down |
| freq_sel | input | 2 | Frequency range select |
| drv_en | output | 1 | Serial driver enable (active state) |
| term_en | output | 1 | Output termination enable (idle or active) |
| locked | output | 1 | Lock wait complete |
| band_oh | output | 4 | One-hot frequency band code |

## Verification
A counter that fails to clear on power-down or on a range change shows up on the first relock, because `drv_en` then rises earlier than LOCK_CYCLES edges after `term_en`. An off-by-one in the terminal count moves that edge by one cycle, which an edge-exact sample catches. A synchronizer that releases too early, or that waits for the clock before clearing, is visible either within two edges of release or within one time step of the power-down. A wrong band decode appears on `band_oh` one edge after the select changes.

// File: rtl/pwr_lock_pkg.sv
package pwr_lock_pkg;
  localparam int SEL_W     = 2;
  localparam int NUM_BANDS = 1 << SEL_W;

  typedef enum logic [1:0] {
    OUT_OFF  = 2'd0,
    OUT_IDLE = 2'd1,
    OUT_DATA = 2'd2
  } out_mode_e;
endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic run_sync
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  // assertion clears every stage at once; release ripples through the stages
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign run_sync = stage_q[STAGES-1];
endmodule

// File: rtl/lock_timer.sv
module lock_timer #(
  parameter int CYCLES = 16385
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic done
);
  localparam int CW = $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!run || restart) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) done_d = 1'b1;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/band_decode.sv
module band_decode
  import pwr_lock_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEL_W-1:0]     sel,
  output logic                 sel_changed,
  output logic [NUM_BANDS-1:0] band_oh
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel;
  end

  assign sel_changed = (sel != sel_q);

  for (genvar k = 0; k < NUM_BANDS; k++) begin : g_band
    assign band_oh[k] = (sel_q == SEL_W'(k));
  end
endmodule

// File: rtl/pwr_lock_ctrl.sv
module pwr_lock_ctrl
  import pwr_lock_pkg::*;
#(
  parameter int LOCK_CYCLES = 16385,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_req,
  input  logic                 vin_ok,
  input  logic [SEL_W-1:0]     freq_sel,
  output logic                 drv_en,
  output logic                 term_en,
  output logic                 locked,
  output logic [NUM_BANDS-1:0] band_oh
);
  logic      clr_n;
  logic      run_sync;
  logic      sel_changed;
  logic      wait_done;
  out_mode_e mode;

  // a missing input supply acts as a power-down request
  assign clr_n = rst_n & run_req & vin_ok;

  pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .clr_n    (clr_n),
    .run_sync (run_sync)
  );

  band_decode u_band (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (freq_sel),
    .sel_changed (sel_changed),
    .band_oh     (band_oh)
  );

  lock_timer #(.CYCLES(LOCK_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_sync),
    .restart (sel_changed),
    .done    (wait_done)
  );

  always_comb begin
    if (!run_sync)      mode = OUT_OFF;
    else if (wait_done) mode = OUT_DATA;
    else                mode = OUT_IDLE;
  end

  assign term_en = (mode != OUT_OFF);
  assign drv_en  = (mode == OUT_DATA);
  assign locked  = (mode == OUT_DATA);
endmodule

// File: rtl/pwr_lock_ctrl_chk.sv
module pwr_lock_ctrl_chk
  import pwr_lock_pkg::*;
#(
  parameter int LOCK_CYCLES = 16385
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 run_req,
  input logic                 vin_ok,
  input logic [SEL_W-1:0]     freq_sel,
  input logic                 drv_en,
  input logic                 term_en,
  input logic                 locked,
  input logic [NUM_BANDS-1:0] band_oh
);
  logic [31:0] term_run;
  logic        past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_run <= '0;
      past_ok  <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (!term_en)                term_run <= '0;
      else if (term_run != '1)     term_run <= term_run + 1'b1;
    end
  end

  AST_DOWN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_req || !vin_ok) |-> (!term_en && !drv_en)); // R2
  AST_TERM_FOR_DRV: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> term_en); // R10
  AST_LOCK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (term_run >= 32'(LOCK_CYCLES))); // R5
  AST_LOCK_WITH_DRV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $rose(drv_en)); // R6
  AST_RANGE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && freq_sel != $past(freq_sel)) |=> !drv_en); // R8
  AST_BAND_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(band_oh) == 1); // R9
  AST_BAND_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (band_oh == (NUM_BANDS'(1) << $past(freq_sel)))); // R9
endmodule

bind pwr_lock_ctrl pwr_lock_ctrl_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_req  (run_req),
  .vin_ok   (vin_ok),
  .freq_sel (freq_sel),
  .drv_en   (drv_en),
  .term_en  (term_en),
  .locked   (locked),
  .band_oh  (band_oh)
);

// File: tb/tb_pwr_lock_ctrl.sv
module tb_pwr_lock_ctrl;
  localparam int N = 16385;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       run_req;
  logic       vin_ok;
  logic [1:0] freq_sel;
  logic       drv_en, term_en, locked;
  logic [3:0] band_oh;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pwr_lock_ctrl dut (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .vin_ok(vin_ok),
    .freq_sel(freq_sel), .drv_en(drv_en), .term_en(term_en),
    .locked(locked), .band_oh(band_oh)
  );

  function automatic logic [3:0] exp_band(input logic [1:0] s);
    return 4'b0001 << s;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // advance to just after the next rising edge; check the always-true relations
  task automatic tick();
    @(posedge clk);
    #5;
    chk("R10 drv needs term", {7'd0, drv_en & ~term_en}, 8'd0);
    chk("R6 locked==drv", {7'd0, locked}, {7'd0, drv_en});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // release power-down and check the idle entry and the exact lock edge
  task automatic relock(input string req);
    run_req = 1'b1;
    tick();
    chk({"R4 term after 1 edge ", req}, {7'd0, term_en}, 8'd0);
    tick();
    chk({"R4 term after 2 edges ", req}, {7'd0, term_en}, 8'd1);
    chk({"R4 idle drv ", req}, {7'd0, drv_en}, 8'd0);
    ticks(N - 1);
    chk({"R5 drv before wait ", req}, {7'd0, drv_en}, 8'd0);
    tick();
    chk({"R5 drv at wait ", req}, {7'd0, drv_en}, 8'd1);
    chk({"R6 locked at wait ", req}, {7'd0, locked}, 8'd1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; run_req = 1'b0; vin_ok = 1'b1; freq_sel = 2'd0;
    ticks(3);
    chk("R1 term", {7'd0, term_en}, 8'd0);
    chk("R1 drv", {7'd0, drv_en}, 8'd0);
    chk("R1 locked", {7'd0, locked}, 8'd0);
    chk("R1 band", {4'd0, band_oh}, 8'h01);
    rst_n = 1'b1;
    tick();

    relock("first");
    chk("R9 band sel0", {4'd0, band_oh}, {4'd0, exp_band(2'd0)});

    // asynchronous power-down: no clock edge between request and check
    run_req = 1'b0;
    #1;
    chk("R2 term async", {7'd0, term_en}, 8'd0);
    chk("R2 drv async", {7'd0, drv_en}, 8'd0);
    tick();

    // short random releases never reach lock; each must be discarded (R7)
    for (int r = 0; r < 6; r++) begin
      int w;
      w = 3 + int'($urandom % 500);
      run_req = 1'b1;
      ticks(w + 2);
      chk("R7 partial term", {7'd0, term_en}, 8'd1);
      chk("R7 partial drv", {7'd0, drv_en}, 8'd0);
      run_req = 1'b0;
      #1;
      chk("R2 partial off", {7'd0, term_en}, 8'd0);
      tick();
    end
    relock("R7 after partials");

    // missing input supply with the run request still high
    vin_ok = 1'b0;
    #1;
    chk("R3 term async", {7'd0, term_en}, 8'd0);
    chk("R3 drv async", {7'd0, drv_en}, 8'd0);
    ticks(5);
    chk("R3 held off", {7'd0, term_en}, 8'd0);
    vin_ok = 1'b1;
    run_req = 1'b0;
    tick();
    relock("R3 after supply");

    // range change while active
    freq_sel = 2'd2;
    tick();
    chk("R8 drv dropped", {7'd0, drv_en}, 8'd0);
    chk("R8 term kept", {7'd0, term_en}, 8'd1);
    chk("R9 band sel2", {4'd0, band_oh}, {4'd0, exp_band(2'd2)});
    ticks(N - 1);
    chk("R8 drv before wait", {7'd0, drv_en}, 8'd0);
    tick();
    chk("R8 drv relocked", {7'd0, drv_en}, 8'd1);

    // random selects: band follows one edge later
    for (int r = 0; r < 24; r++) begin
      logic [1:0] s;
      s = 2'($urandom % 4);
      freq_sel = s;
      tick();
      chk("R9 band random", {4'd0, band_oh}, {4'd0, exp_band(s)});
      chk("R8 term random", {7'd0, term_en}, 8'd1);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule